// File: doc/BRIEF.md
# Receive Bit Clock Recovery Loop

This block rebuilds the receive bit clock of a narrowband frequency-shift modem from the hard-decision bit stream that the demodulator delivers. A prescaler divides the master clock into sixteen phase steps per bit, and a four-bit phase counter walks through those steps. The top bit of the counter is the recovered clock. Each transition seen on the synchronised input is compared with the counter position. The next phase step is then repeated or skipped, which pulls the clock falling edge onto the data transitions. The rising edge therefore lands in the middle of the bit.

The input level is captured at each rising edge of the recovered clock. It is presented on the data output at the following falling edge, together with a one-cycle strobe. A rate select picks one of two prescaler divisors, so the bit rate can be halved or doubled without changing the step count. Reset returns the loop to its initial state, and the receive path holds reset during full power down.

Top module: `rx_bitclk_dpll`

## Requirements
- R1: With no input transitions, `rclk_out` is periodic with a period of 16*DIV_SLOW clock cycles when `rate_fast`=0 and 16*DIV_FAST cycles when `rate_fast`=1.
- R2: `bit_strobe` is high for exactly the cycles in which `rclk_out` has just fallen from 1 to 0, and `rdata_out` changes only in such a cycle.
- R3: The value placed on `rdata_out` at a falling edge of `rclk_out` is the synchronised input level at the preceding rising edge (mid-bit), so a received bit appears one bit time after it started.
- R4: On an alternating 0/1 input at the nominal bit period, the distance between an input transition and the nearest `rclk_out` falling edge is at most 4 phase steps (90 degrees) by the 11th bit, whatever the starting phase.
- R5: On the same input, that distance is at most one phase step (22.5 degrees) for every bit from the 18th onwards.
- R6: The phase counter moves only on a prescaler tick and then by 0, 1 or 2 steps. A transition seen at phase 1..7 repeats one step, one seen at phase 8..15 skips one, and one at phase 0 changes nothing. On an alternating input each `rclk_out` period therefore lasts 15, 16 or 17 phase steps.
- R7: `rst_n` low forces `rclk_out`, `rdata_out` and `bit_strobe` to 0 at once. Release passes a two-flop synchroniser, and the first `rclk_out` rise follows release by 8 phase steps, within 8*DIV+4 clock cycles.
- R8: When the input bit period is longer than nominal by less than one phase step, the loop keeps the transition-to-falling-edge distance within 2 phase steps once locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, also asserted in full power down |
| rx_bit_raw | input | 1 | Hard-decision demodulated bit, asynchronous to clk |
| rate_fast | input | 1 | 0 selects the low bit rate (DIV_SLOW), 1 the high bit rate (DIV_FAST) |
| rclk_out | output | 1 | Recovered bit clock; falls on data transitions, rises mid-bit |
| rdata_out | output | 1 | Retimed receive data, updated on the falling edge of rclk_out |
| bit_strobe | output | 1 | One-cycle pulse marking each update of rdata_out |

## Verification
The hardest situation to reach is the locked steady state, where each transition falls right at the counter wrap and the loop alternates between no correction and one-step corrections. It can only be observed as a time distance between two port events. The stimulus drives an alternating preamble that starts at several chosen offsets after reset, including a half-bit offset that gives the largest initial error. The distance is measured in clock cycles at mid-bit of the 11th and later bits. A run whose input period is deliberately long keeps the loop correcting all the time. A pseudo-random payload after lock then checks the retimed data through a scoreboard.

// File: rtl/rxdpll_pkg.sv
package rxdpll_pkg;

  // correction requested by the last observed input transition
  typedef enum logic [1:0] {
    ADJ_NONE = 2'd0,
    ADJ_HOLD = 2'd1,   // repeat one phase step (local clock early)
    ADJ_SKIP = 2'd2    // skip one phase step (local clock late)
  } adj_e;

endpackage

// File: rtl/rxdpll_sync.sv
module rxdpll_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic edge_o
);

  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[0] <= 1'b0;
          else        sh_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[g] <= 1'b0;
          else        sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sh_q[STAGES-1];
  end

  assign dout   = sh_q[STAGES-1];
  assign edge_o = sh_q[STAGES-1] ^ prev_q;

  // an edge pulse never lasts two cycles: the history register catches up
  p_edge_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> (prev_q == $past(dout)));

endmodule

// File: rtl/rxdpll_presc.sv
module rxdpll_presc #(
  parameter int DIV_SLOW = 192,
  parameter int DIV_FAST = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_sel,
  output logic tick_o
);

  localparam int CW = $clog2(DIV_SLOW);
  localparam logic [CW-1:0] LIM_SLOW = CW'(DIV_SLOW - 1);
  localparam logic [CW-1:0] LIM_FAST = CW'(DIV_FAST - 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          at_end;

  always_comb begin
    lim    = fast_sel ? LIM_FAST : LIM_SLOW;
    at_end = (cnt_q >= lim);
    cnt_d  = at_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = at_end;

  // ticks are isolated pulses, one per divisor period
  p_tick_isolated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  p_count_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM_SLOW);

endmodule

// File: rtl/rxdpll_phase.sv
module rxdpll_phase
  import rxdpll_pkg::*;
#(
  parameter int PHASES = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_i,
  input  logic                      edge_i,
  output logic [$clog2(PHASES)-1:0] phase_o,
  output logic                      wrap_o,
  output logic                      mid_o
);

  localparam int PW = $clog2(PHASES);

  logic [PW-1:0] phase_q, phase_d;
  logic [PW:0]   sum;
  logic [1:0]    inc;
  adj_e          pend_q, pend_d, req;

  // classify the transition against the nominal edge position (phase 0)
  always_comb begin
    if (phase_q == '0)          req = ADJ_NONE;
    else if (!phase_q[PW-1])    req = ADJ_HOLD;
    else                        req = ADJ_SKIP;
  end

  always_comb begin
    pend_d = pend_q;
    if (tick_i) pend_d = ADJ_NONE;
    if (edge_i) pend_d = req;
  end

  always_comb begin
    inc = 2'd0;
    if (tick_i) begin
      unique case (pend_q)
        ADJ_HOLD: inc = 2'd0;
        ADJ_SKIP: inc = 2'd2;
        default:  inc = 2'd1;
      endcase
    end
    sum     = {1'b0, phase_q} + {{(PW-1){1'b0}}, inc};
    phase_d = sum[PW-1:0];
    wrap_o  = sum[PW];
    mid_o   = !phase_q[PW-1] && phase_d[PW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      pend_q  <= ADJ_NONE;
    end else begin
      phase_q <= phase_d;
      pend_q  <= pend_d;
    end
  end

  assign phase_o = phase_q;

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(phase_q));

  p_step_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (PW'(phase_q - $past(phase_q)) <= PW'(2)));

endmodule

// File: rtl/rxdpll_retime.sv
module rxdpll_retime (
  input  logic clk,
  input  logic rst_n,
  input  logic mid_i,
  input  logic wrap_i,
  input  logic din_i,
  output logic data_o,
  output logic strobe_o
);

  logic smp_q, smp_d;
  logic data_q, data_d;
  logic stb_q;

  always_comb begin
    smp_d  = mid_i  ? din_i : smp_q;
    data_d = wrap_i ? smp_q : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= 1'b0;
      data_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      smp_q  <= smp_d;
      data_q <= data_d;
      stb_q  <= wrap_i;
    end
  end

  assign data_o   = data_q;
  assign strobe_o = stb_q;

  p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_o |-> $stable(data_o));

endmodule

// File: rtl/rx_bitclk_dpll.sv
module rx_bitclk_dpll #(
  parameter int DIV_SLOW    = 192,
  parameter int DIV_FAST    = 96,
  parameter int PHASES      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bit_raw,
  input  logic rate_fast,
  output logic rclk_out,
  output logic rdata_out,
  output logic bit_strobe
);

  localparam int PW = $clog2(PHASES);

  logic          rst_meta, rst_q;
  logic          bit_s, bit_edge, tick;
  logic [PW-1:0] phase;
  logic          wrap, mid;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  rxdpll_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q), .din(rx_bit_raw),
    .dout(bit_s), .edge_o(bit_edge)
  );

  rxdpll_presc #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_presc (
    .clk(clk), .rst_n(rst_q), .fast_sel(rate_fast), .tick_o(tick)
  );

  rxdpll_phase #(.PHASES(PHASES)) u_phase (
    .clk(clk), .rst_n(rst_q), .tick_i(tick), .edge_i(bit_edge),
    .phase_o(phase), .wrap_o(wrap), .mid_o(mid)
  );

  rxdpll_retime u_retime (
    .clk(clk), .rst_n(rst_q), .mid_i(mid), .wrap_i(wrap), .din_i(bit_s),
    .data_o(rdata_out), .strobe_o(bit_strobe)
  );

  assign rclk_out = phase[PW-1];

  p_strobe_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_q)
    bit_strobe |-> (!rclk_out && $past(rclk_out)));

  p_fall_has_strobe_r2: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(rclk_out) |-> bit_strobe);

endmodule

// File: tb/rx_bitclk_dpll_test.sv
module rx_bitclk_dpll_test;

  localparam int CLK_PERIOD = 10;
  localparam int P_SLOW = 24;
  localparam int P_FAST = 12;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit_raw = 1'b0;
  logic rate_fast = 1'b0;
  logic rclk_out, rdata_out, bit_strobe;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // monitor state
  logic rt_prev = 1'b0, rd_prev = 1'b0, rst_prev = 1'b0;
  int   last_fall = 0, last_rise = 0, rise_cnt = 0;
  bit   fall_valid = 1'b0, per_chk = 1'b0;
  int   cur_p = P_FAST;
  logic exp_q[$];
  int   pushed = 0, popped = 0;

  rx_bitclk_dpll #(.DIV_SLOW(P_SLOW), .DIV_FAST(P_FAST)) uut (
    .clk(clk), .rst_n(rst_n), .rx_bit_raw(rx_bit_raw), .rate_fast(rate_fast),
    .rclk_out(rclk_out), .rdata_out(rdata_out), .bit_strobe(bit_strobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > WD_LIMIT && !finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog", cyc, WD_LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // monitor and scoreboard consumer
  always @(negedge clk) begin
    if (rst_n && rst_prev) begin
      if (rt_prev && !rclk_out) begin
        if (per_chk && fall_valid) begin
          int d;
          d = cyc - last_fall;
          // R6: period of 15, 16 or 17 steps on alternating input
          check(d == 15*cur_p || d == 16*cur_p || d == 17*cur_p,
                "R6 rclk period", d, 16*cur_p);
        end
        last_fall = cyc;
        fall_valid = 1'b1;
      end
      if (!rt_prev && rclk_out) begin
        last_rise = cyc;
        rise_cnt++;
      end
      if (bit_strobe !== (rt_prev && !rclk_out))
        check(1'b0, "R2 strobe vs fall", int'(bit_strobe), int'(rt_prev && !rclk_out));
      if (!bit_strobe && rdata_out !== rd_prev)
        check(1'b0, "R2 data change without strobe", int'(rdata_out), int'(rd_prev));
      if (bit_strobe && exp_q.size() > 0) begin
        logic e;
        e = exp_q.pop_front();
        popped++;
        check(rdata_out === e, "R3 retimed data", int'(rdata_out), int'(e));
      end
    end
    rt_prev  = rclk_out;
    rd_prev  = rdata_out;
    rst_prev = rst_n;
  end

  task automatic do_reset(input logic fast);
    @(negedge clk);
    rst_n = 1'b0;
    rx_bit_raw = 1'b0;
    rate_fast = fast;
    cur_p = fast ? P_FAST : P_SLOW;
    per_chk = 1'b0;
    fall_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R7: outputs cleared while reset is low
    check(rclk_out === 1'b0 && rdata_out === 1'b0 && bit_strobe === 1'b0,
          "R7 reset outputs", {rclk_out, rdata_out, bit_strobe}, 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_rise(input int n);
    int target;
    target = rise_cnt + n;
    while (rise_cnt < target) @(negedge clk);
  endtask

  // drive one bit; optionally measure phase error at mid-bit
  task automatic send_bit(input logic b, input int per, input int k,
                          input int lim_k, input int lim_err, input bit push);
    int t_in, d, err;
    rx_bit_raw = b;
    t_in = cyc;
    repeat (per/2) @(negedge clk);
    if (push) begin
      exp_q.push_back(b);
      pushed++;
    end
    if (lim_k > 0 && k >= lim_k) begin
      d = last_fall - t_in;
      err = (d < 0) ? -d : d;
      if (per - err < err) err = per - err;
      if (lim_err == 4*cur_p)
        check(err <= lim_err, "R4 lock to 90 deg", err, lim_err);
      else if (lim_err == cur_p)
        check(err <= lim_err, "R5 lock to 22.5 deg", err, lim_err);
      else
        check(err <= lim_err, "R8 tracking offset rate", err, lim_err);
    end
    repeat (per - per/2) @(negedge clk);
  endtask

  task automatic preamble(input int nbits, input int per, input bit drift);
    per_chk = !drift;
    for (int k = 1; k <= nbits; k++) begin
      logic b;
      b = (k % 2 == 1);
      if (drift)
        send_bit(b, per, k, 20, 2*cur_p, 1'b0);
      else if (k == 11)
        send_bit(b, per, k, 11, 4*cur_p, 1'b0);
      else if (k >= 18)
        send_bit(b, per, k, 18, cur_p, 1'b0);
      else
        send_bit(b, per, k, 0, 0, 1'b0);
    end
    per_chk = 1'b0;
  endtask

  task automatic payload(input int nbits, input logic [7:0] seed);
    logic [7:0] lf;
    lf = seed;
    for (int k = 0; k < nbits; k++) begin
      send_bit(lf[0], 16*cur_p, 0, 0, 0, 1'b1);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end
    // pad bit so that the last payload bit reaches the output
    send_bit(~rx_bit_raw, 16*cur_p, 0, 0, 0, 1'b0);
    repeat (4) @(negedge clk);
  endtask

  task automatic free_run(input logic fast);
    int rel, d;
    do_reset(fast);
    rel = cyc;
    wait_rise(1);
    d = last_rise - rel;
    // R7: first rise 8 steps after release
    check(d >= 8*cur_p && d <= 8*cur_p + 4, "R7 first rise delay", d, 8*cur_p);
    rel = last_rise;
    wait_rise(1);
    d = last_rise - rel;
    // R1: free-running period
    check(d == 16*cur_p, "R1 rclk period", d, 16*cur_p);
    rel = last_rise;
    wait_rise(1);
    d = last_rise - rel;
    check(d == 16*cur_p, "R1 rclk period repeat", d, 16*cur_p);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (2) @(negedge clk);

    free_run(1'b0);
    free_run(1'b1);

    // run 1: fast rate, half-bit starting offset, then payload
    do_reset(1'b1);
    repeat (8*P_FAST) @(negedge clk);
    preamble(20, 16*P_FAST, 1'b0);
    payload(16, 8'hA5);

    // run 2: fast rate, small offset
    do_reset(1'b1);
    repeat (3*P_FAST + 1) @(negedge clk);
    preamble(20, 16*P_FAST, 1'b0);

    // run 3: slow rate, late offset, then payload
    do_reset(1'b0);
    repeat (13*P_SLOW + 5) @(negedge clk);
    preamble(20, 16*P_SLOW, 1'b0);
    payload(12, 8'h3C);

    // run 4: fast rate, input period two cycles long (R8)
    do_reset(1'b1);
    repeat (5*P_FAST) @(negedge clk);
    preamble(30, 16*P_FAST + 2, 1'b1);

    // R3: every pushed bit was compared
    check(exp_q.size() == 0 && popped == pushed, "R3 scoreboard drained", popped, pushed);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule